// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filtering

This block receives asynchronous 9-bit frames from a shared multidrop line and hands each completed frame to the host. A frame carries one byte plus a ninth flag bit. The flag bit marks the byte as a node address (flag 1) or as ordinary data (flag 0). The line is sampled at sixteen times the bit rate. The sample rate comes from a programmable clock divider.

The host programs a node address and a per-bit compare mask. When the host turns on filtering, the receiver wakes the host only for address frames meant for this node. A frame qualifies in two cases. The first is a direct masked match. The second is a match against the node's broadcast pattern, which is derived from the address and the mask. After a match the host turns filtering off, so that the data frames that follow raise the interrupt. It turns filtering back on when the message is over.

With filtering off, every well-formed frame is delivered. A rejected frame, or a frame with a framing error, leaves the outputs exactly as they were.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `irq_o` is 0, `data_o` is 0x00 and `flag_o` is 0.
- R2: A sample tick occurs once every `baud_div_i`+1 clocks, and one bit lasts 16 ticks. A frame is: the line idling high, a low start bit, 8 data bits sent LSB first, the flag bit, and a high stop bit. Each bit is taken at mid-bit.
- R3: With `filt_en_i` = 0, every frame whose stop bit is high loads `data_o` and `flag_o` and sets `irq_o`, whatever the flag value.
- R4: `irq_o` stays 1 until `irq_clr_i` is high on a clock edge. A frame accepted on that same edge keeps `irq_o` at 1.
- R5: With `filt_en_i` = 1, a frame whose flag bit is 0 is ignored. `data_o`, `flag_o` and `irq_o` do not change.
- R6: With `filt_en_i` = 1 and flag 1, a byte matches directly when it equals `addr_i` in every bit where `mask_i` is 1. Bits where the mask is 0 are not compared. Examples with `addr_i` = 0x35: mask 0x0F accepts 0xA5 and 0xF5, and mask 0xF3 accepts 0x31 and 0x39.
- R7: The broadcast pattern is `addr_i` OR `mask_i`. With filtering on and flag 1, a byte also matches when it has a 1 in every position where that pattern has a 1. Examples: with address 0x35, the byte 0xFF is accepted under masks 0x0F, 0xF3 and 0xC0. The byte 0x3F is accepted under mask 0x0F. The byte 0xF5 is rejected under mask 0xF3.
- R8: With `filt_en_i` = 1, a flag-1 frame that matches neither way is ignored and the outputs hold. Examples with address 0x35: 0x40 under mask 0xC0, and 0x3E under mask 0x0F.
- R9: A start bit that is high again at its middle sample is dropped as a glitch. It produces no frame and no interrupt, and the next real frame is received normally.
- R10: A frame whose stop bit samples low is discarded in either filter mode. No output changes. The receiver waits for the line to return high before it looks for the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idles high |
| baud_div_i | input | 16 | Clocks per sample tick, minus one |
| filt_en_i | input | 1 | Address-filter mode enable |
| addr_i | input | 8 | Node address |
| mask_i | input | 8 | Per-bit compare mask for the address (1 = compare) |
| irq_clr_i | input | 1 | Clears the receive interrupt flag |
| data_o | output | 8 | Last accepted byte |
| flag_o | output | 1 | Flag bit of the last accepted frame |
| irq_o | output | 1 | Receive interrupt flag |

## Verification
Some internal faults show up within one frame time: a bit counter off by one, a shift in the wrong direction, or a bad mid-bit point. They appear at the ports as a wrong byte or flag value on the first frame that has asymmetric bits. A wrong match term is different. It shows only as `irq_o` being wrong for the specific address and mask pairs that exercise that term, so the vector table pairs each mask with bytes that separate a direct match from a broadcast match. A receiver that fails to recover after a glitch or a framing error stays hidden until the next frame, which the bench therefore sends and checks at once.

// File: rtl/mp_uart_pkg.sv
`timescale 1ns/1ps
package mp_uart_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP,
    RX_BREAK
  } rx_state_e;
endpackage

// File: rtl/mp_uart_tick.sv
`timescale 1ns/1ps
module mp_uart_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= so a lowered divisor never waits for a full wrap
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mp_uart_deser.sv
`timescale 1ns/1ps
module mp_uart_deser
  import mp_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              frm_vld_o,
  output logic              frm_ok_o,
  output logic [DATA_W-1:0] frm_data_o,
  output logic              frm_flag_o
);
  localparam int FRM_BITS = DATA_W + 1;
  localparam int CNT_W    = $clog2(OVS);
  localparam int IDX_W    = $clog2(FRM_BITS + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FRM_BITS - 1);

  logic [1:0]          sync_q;
  logic                rx_s;
  rx_state_e           state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [IDX_W-1:0]    idx_q;
  logic [FRM_BITS-1:0] shr_q;

  assign rx_s = sync_q[1];
  assign frm_data_o = shr_q[DATA_W-1:0];
  assign frm_flag_o = shr_q[FRM_BITS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shr_q     <= '0;
      frm_vld_o <= 1'b0;
      frm_ok_o  <= 1'b0;
    end else begin
      frm_vld_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          if (tick_i && !rx_s) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end
        RX_START: begin
          if (tick_i) begin
            if (cnt_q == MID) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= rx_s ? RX_IDLE : RX_BITS;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick_i) begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              shr_q <= {rx_s, shr_q[FRM_BITS-1:1]};
              idx_q <= idx_q + 1'b1;
              if (idx_q == IDX_END) state_q <= RX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick_i) begin
            if (cnt_q == LAST) begin
              cnt_q     <= '0;
              frm_vld_o <= 1'b1;
              frm_ok_o  <= rx_s;
              state_q   <= rx_s ? RX_IDLE : RX_BREAK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RX_BREAK: begin
          if (rx_s) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mp_uart_addr_match.sv
`timescale 1ns/1ps
module mp_uart_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] dir_ok;
  logic [DATA_W-1:0] bc_ok;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign dir_ok[i] = !mask_i[i] || (data_i[i] == addr_i[i]);
    // broadcast pattern bit = addr|mask; zeros are don't-care
    assign bc_ok[i]  = !(addr_i[i] || mask_i[i]) || data_i[i];
  end

  assign hit_o = (&dir_ok) || (&bc_ok);
endmodule

// File: rtl/mp_uart_rx.sv
`timescale 1ns/1ps
module mp_uart_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              filt_en_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              irq_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic              tick;
  logic              frm_vld;
  logic              frm_ok;
  logic [DATA_W-1:0] frm_data;
  logic              frm_flag;
  logic              addr_hit;
  logic              frm_accept;

  mp_uart_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (baud_div_i),
    .tick_o (tick)
  );

  mp_uart_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .rx_i       (rx_i),
    .frm_vld_o  (frm_vld),
    .frm_ok_o   (frm_ok),
    .frm_data_o (frm_data),
    .frm_flag_o (frm_flag)
  );

  mp_uart_addr_match #(.DATA_W(DATA_W)) u_match (
    .data_i (frm_data),
    .addr_i (addr_i),
    .mask_i (mask_i),
    .hit_o  (addr_hit)
  );

  assign frm_accept = frm_vld && frm_ok && (!filt_en_i || (frm_flag && addr_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      flag_o <= 1'b0;
    end else if (frm_accept) begin
      data_o <= frm_data;
      flag_o <= frm_flag;
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         irq_o <= 1'b0;
    else if (frm_accept) irq_o <= 1'b1;
    else if (irq_clr_i)  irq_o <= 1'b0;
  end
endmodule

// File: rtl/mp_uart_rx_chk.sv
`timescale 1ns/1ps
module mp_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              filt_en_i,
  input logic [DATA_W-1:0] addr_i,
  input logic [DATA_W-1:0] mask_i,
  input logic              irq_clr_i,
  input logic [DATA_W-1:0] data_o,
  input logic              flag_o,
  input logic              irq_o,
  input logic              frm_vld_i,
  input logic              frm_ok_i,
  input logic              frm_accept_i
);
  assert_irq_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);

  assert_clr_wins_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !frm_accept_i |=> !irq_o);

  assert_data_moves_with_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> irq_o);

  assert_filter_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) && $past(filt_en_i) |-> flag_o);

  assert_filter_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) && $past(filt_en_i) |->
      ((((data_o ^ $past(addr_i)) & $past(mask_i)) == '0) ||
       ((data_o & ($past(addr_i) | $past(mask_i))) == ($past(addr_i) | $past(mask_i)))));

  assert_frame_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_i && !frm_ok_i && !irq_clr_i |=> (irq_o == $past(irq_o)) && $stable(data_o) && $stable(flag_o));
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .filt_en_i    (filt_en_i),
  .addr_i       (addr_i),
  .mask_i       (mask_i),
  .irq_clr_i    (irq_clr_i),
  .data_o       (data_o),
  .flag_o       (flag_o),
  .irq_o        (irq_o),
  .frm_vld_i    (frm_vld),
  .frm_ok_i     (frm_ok),
  .frm_accept_i (frm_accept)
);

// File: tb/sim_mp_uart_rx.sv
`timescale 1ns/1ps
module sim_mp_uart_rx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx = 1'b1;
  logic [15:0] div = 16'd1;
  logic        filt = 1'b0;
  logic [7:0]  addr = 8'h35;
  logic [7:0]  mask = 8'h0F;
  logic        clr = 1'b0;
  logic [7:0]  data_o;
  logic        flag_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] last_data = 8'h00;
  logic       last_flag = 1'b0;

  always #2.5 clk = ~clk;

  mp_uart_rx u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rx_i       (rx),
    .baud_div_i (div),
    .filt_en_i  (filt),
    .addr_i     (addr),
    .mask_i     (mask),
    .irq_clr_i  (clr),
    .data_o     (data_o),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
  );

  // {req[3:0], filt, addr, mask, byte, flag, expect_accept}
  localparam int NV = 14;
  localparam logic [30:0] VEC [NV] = '{
    {4'd3, 1'b0, 8'h35, 8'h0F, 8'h12, 1'b0, 1'b1},  // R3 data frame, filter off
    {4'd3, 1'b0, 8'h35, 8'h0F, 8'h9C, 1'b1, 1'b1},  // R3 flag 1, filter off
    {4'd6, 1'b1, 8'h35, 8'h0F, 8'hA5, 1'b1, 1'b1},  // R6 masked match
    {4'd5, 1'b1, 8'h35, 8'h0F, 8'hA5, 1'b0, 1'b0},  // R5 flag 0 ignored
    {4'd6, 1'b1, 8'h35, 8'h0F, 8'hF5, 1'b1, 1'b1},  // R6
    {4'd7, 1'b1, 8'h35, 8'hF3, 8'hF5, 1'b1, 1'b0},  // R7 F5 rejected by mask F3
    {4'd7, 1'b1, 8'h35, 8'hC0, 8'hFF, 1'b1, 1'b1},  // R7 all-ones broadcast
    {4'd7, 1'b1, 8'h35, 8'hF3, 8'hFF, 1'b1, 1'b1},  // R7
    {4'd6, 1'b1, 8'h35, 8'hF3, 8'h31, 1'b1, 1'b1},  // R6
    {4'd6, 1'b1, 8'h35, 8'hF3, 8'h39, 1'b1, 1'b1},  // R6 don't-care bits
    {4'd8, 1'b1, 8'h35, 8'hC0, 8'h40, 1'b1, 1'b0},  // R8 no match
    {4'd7, 1'b1, 8'h35, 8'h0F, 8'h3F, 1'b1, 1'b1},  // R7 broadcast only
    {4'd8, 1'b1, 8'h35, 8'h0F, 8'h3E, 1'b1, 1'b0},  // R8 no match
    {4'd7, 1'b1, 8'h35, 8'h0F, 8'hFF, 1'b1, 1'b1}   // R7
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic v);
    rx = v;
    repeat (16 * (int'(div) + 1)) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic f, input logic stop);
    bit_time(1'b0);
    for (int i = 0; i < 8; i++) bit_time(b[i]);
    bit_time(f);
    bit_time(stop);
    bit_time(1'b1);
    bit_time(1'b1);
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    chk(data_o == 8'h00, "R1 data", data_o, 0);
    chk(flag_o == 1'b0, "R1 flag", flag_o, 0);
    rst_ni = 1'b1;
    repeat (40) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [30:0] v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d vec%0d", v[30:27], k);
      filt = v[26];
      addr = v[25:18];
      mask = v[17:10];
      pulse_clr();
      send_frame(v[9:2], v[1], 1'b1);
      chk(irq_o == v[0], {tag, " irq"}, irq_o, v[0]);
      if (v[0]) begin
        last_data = v[9:2];
        last_flag = v[1];
      end
      chk(data_o == last_data, {tag, " data"}, data_o, last_data);
      chk(flag_o == last_flag, {tag, " flag"}, flag_o, last_flag);
    end

    // R4 flag holds without clear, then clears
    filt = 1'b0;
    pulse_clr();
    send_frame(8'h5A, 1'b0, 1'b1);
    repeat (200) @(negedge clk);
    chk(irq_o == 1'b1, "R4 hold", irq_o, 1);
    chk(data_o == 8'h5A, "R4 data", data_o, 8'h5A);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(irq_o == 1'b0, "R4 clear", irq_o, 0);
    last_data = 8'h5A;
    last_flag = 1'b0;

    // R9 start glitch shorter than half a bit
    rx = 1'b0;
    repeat (4 * (int'(div) + 1)) @(negedge clk);
    rx = 1'b1;
    repeat (64 * (int'(div) + 1)) @(negedge clk);
    chk(irq_o == 1'b0, "R9 glitch irq", irq_o, 0);
    chk(data_o == last_data, "R9 glitch data", data_o, last_data);
    send_frame(8'h81, 1'b1, 1'b1);
    chk(irq_o == 1'b1, "R9 recover irq", irq_o, 1);
    chk(data_o == 8'h81, "R9 recover data", data_o, 8'h81);
    last_data = 8'h81;
    last_flag = 1'b1;

    // R10 framing error, filter off then on
    pulse_clr();
    send_frame(8'h77, 1'b1, 1'b0);
    chk(irq_o == 1'b0, "R10 ferr irq off", irq_o, 0);
    chk(data_o == last_data, "R10 ferr data", data_o, last_data);
    filt = 1'b1; addr = 8'h35; mask = 8'h0F;
    send_frame(8'hFF, 1'b1, 1'b0);
    chk(irq_o == 1'b0, "R10 ferr irq on", irq_o, 0);
    chk(flag_o == last_flag, "R10 ferr flag", flag_o, last_flag);
    filt = 1'b0;
    send_frame(8'h3C, 1'b0, 1'b1);
    chk(irq_o == 1'b1, "R10 recover irq", irq_o, 1);
    chk(data_o == 8'h3C, "R10 recover data", data_o, 8'h3C);

    // R2 slower sample rate, asymmetric byte
    div = 16'd3;
    repeat (20) @(negedge clk);
    pulse_clr();
    send_frame(8'hC1, 1'b1, 1'b1);
    chk(irq_o == 1'b1, "R2 div3 irq", irq_o, 1);
    chk(data_o == 8'hC1, "R2 div3 data", data_o, 8'hC1);
    chk(flag_o == 1'b1, "R2 div3 flag", flag_o, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule